// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a row of flip-flops that a two-bit operation select steers through four actions on each rising clock edge: keep the stored word, move every bit one place toward the least significant end, move every bit one place toward the most significant end, or capture a full parallel word. Each direction of movement has its own serial fill input. The bit that enters at the top during a downward move comes from one input, and the bit that enters at the bottom during an upward move comes from the other. All stage values are visible at once on the parallel output.

An active-low clear drives every stage to zero at once, without waiting for the clock, and it overrides the operation select while it is low. Stage 0 is the least significant bit and stage W-1 the most significant. The width W defaults to 4 and must be at least 2. Ring, twisted-ring and longer chains are built outside the block by wiring the outputs back to the fill inputs.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `arst_n` is 0, `q` reads all zeros at once, without waiting for a clock edge.
- R2: With `op_sel` = 2'b00 at a rising edge, `q` keeps its value.
- R3: With `op_sel` = 2'b01 at a rising edge, every stage i < W-1 takes the old value of stage i+1, and stage W-1 takes `fill_hi`.
- R4: With `op_sel` = 2'b10 at a rising edge, every stage i > 0 takes the old value of stage i-1, and stage 0 takes `fill_lo`.
- R5: With `op_sel` = 2'b11 at a rising edge, `q` takes `par_in`.
- R6: A rising edge while `arst_n` is 0 leaves `q` at zero whatever `op_sel` and the data inputs are. The first edge after `arst_n` returns to 1 performs the selected operation.
- R7: `fill_lo` has no effect in mode 2'b01, `fill_hi` has no effect in mode 2'b10, and `par_in` has no effect in modes other than 2'b11.
- R8: Apart from the clear, `q` changes only at a rising clock edge. Changing `op_sel` or the data inputs between edges leaves `q` unchanged.
- R9: Bit 0 is the least significant stage. A bit that enters through `fill_hi` appears on `q[0]` after W right shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous clear, active low |
| op_sel | input | 2 | Operation: 00 keep, 01 move toward bit 0, 10 move toward bit W-1, 11 parallel capture |
| fill_hi | input | 1 | Serial bit that enters stage W-1 on a move toward bit 0 |
| fill_lo | input | 1 | Serial bit that enters stage 0 on a move toward bit W-1 |
| par_in | input | W | Parallel word for capture |
| q | output | W | All stage values |

## Verification
The clear and a synchronous operation can meet in the same cycle. The bench holds `arst_n` low across a rising edge while it selects a parallel capture of a non-zero word, and it expects zero after that edge. It then releases the clear with a capture still selected and expects the new word on the very next edge. It also drops the clear between edges and samples `q` before any edge arrives, which shows that the clear does not wait for the clock.

// File: rtl/bsr_pkg.sv
// Package: shared operation encoding for the bidirectional shift register.
// Assumes the encoding is fixed and is decoded by every stage alike.
package bsr_pkg;
    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_DOWN = 2'b01,   // move toward bit 0, fill_hi enters at the top
        OP_UP   = 2'b10,   // move toward bit W-1, fill_lo enters at the bottom
        OP_LOAD = 2'b11
    } bsr_op_e;
endpackage

// File: rtl/bsr_link.sv
// Module: neighbour routing. For each stage it gives the bit that stage
// takes on a move toward bit 0 (from above) and on a move toward bit W-1
// (from below). The fill inputs take the place of the missing neighbours
// at the two ends. Assumes W >= 2.
module bsr_link #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         fill_hi,
    input  logic         fill_lo,
    output logic [W-1:0] from_above,
    output logic [W-1:0] from_below
);
    localparam int TOP = W - 1;

    for (genvar i = 0; i < W; i++) begin : g_route
        if (i == TOP) begin : g_top
            // top stage: fed by fill_hi when moving down
            assign from_above[i] = fill_hi;
        end else begin : g_mid_hi
            // inner stage: fed by the stage above
            assign from_above[i] = cur[i+1];
        end
        if (i == 0) begin : g_bot
            // bottom stage: fed by fill_lo when moving up
            assign from_below[i] = fill_lo;
        end else begin : g_mid_lo
            // inner stage: fed by the stage below
            assign from_below[i] = cur[i-1];
        end
    end
endmodule

// File: rtl/bsr_stage.sv
// Module: one storage stage. A flip-flop with a four-way source select
// and an asynchronous active-low clear. Assumes op is held stable
// around the rising edge.
module bsr_stage
    import bsr_pkg::*;
(
    input  logic    clk,
    input  logic    arst_n,
    input  bsr_op_e op,
    input  logic    from_above,
    input  logic    from_below,
    input  logic    par_bit,
    output logic    q_bit
);
    logic nxt;

    // choose the value this stage takes at the next edge
    always_comb begin
        unique case (op)
            OP_KEEP: nxt = q_bit;
            OP_DOWN: nxt = from_above;
            OP_UP:   nxt = from_below;
            OP_LOAD: nxt = par_bit;
            default: nxt = q_bit;
        endcase
    end

    // storage with the clear taking priority
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q_bit <= 1'b0;
        else         q_bit <= nxt;
    end
endmodule

// File: rtl/bidir_shift_reg.sv
// Module: top of the bidirectional shift register. It joins W stages
// through the neighbour router and exposes all of them in parallel.
// Assumes W >= 2. The clear is asynchronous and active low, because
// the function requires the clear to act without waiting for the clock.
module bidir_shift_reg
    import bsr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [1:0]   op_sel,
    input  logic         fill_hi,
    input  logic         fill_lo,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    localparam int TOP = W - 1;

    bsr_op_e      op;
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;

    // decode the raw select into the shared operation type
    always_comb op = bsr_op_e'(op_sel);

    bsr_link #(.W(W)) u_link (
        .cur        (q),
        .fill_hi    (fill_hi),
        .fill_lo    (fill_lo),
        .from_above (from_above),
        .from_below (from_below)
    );

    for (genvar i = 0; i < W; i++) begin : g_stage
        bsr_stage u_stage (
            .clk        (clk),
            .arst_n     (arst_n),
            .op         (op),
            .from_above (from_above[i]),
            .from_below (from_below[i]),
            .par_bit    (par_in[i]),
            .q_bit      (q[i])
        );
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) !arst_n |-> q == '0) else $error("clear"); // R6
    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!arst_n) op_sel == 2'b00 |=> $stable(q)) else $error("keep"); // R2
    AST_DOWN_MOVE: assert property (@(posedge clk) disable iff (!arst_n) op_sel == 2'b01 |=> q == {$past(fill_hi), $past(q[TOP:1])}) else $error("down"); // R3
    AST_UP_MOVE: assert property (@(posedge clk) disable iff (!arst_n) op_sel == 2'b10 |=> q == {$past(q[TOP-1:0]), $past(fill_lo)}) else $error("up"); // R4
    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!arst_n) op_sel == 2'b11 |=> q == $past(par_in)) else $error("load"); // R5
endmodule

// File: tb/tb_bidir_shift_reg.sv
`timescale 1ns/1ps
module tb_bidir_shift_reg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         arst_n = 1'b1;
    logic [1:0]   op_sel = 2'b00;
    logic         fill_hi = 1'b0;
    logic         fill_lo = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic [W-1:0] cur = '0;

    bidir_shift_reg #(.W(W)) dut (
        .clk(clk), .arst_n(arst_n), .op_sel(op_sel),
        .fill_hi(fill_hi), .fill_lo(fill_lo), .par_in(par_in), .q(q)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] c, input logic rn, input logic [1:0] op,
                                           input logic hi, input logic lo, input logic [W-1:0] p);
        if (!rn) return '0;
        case (op)
            2'b00: return c;
            2'b01: return {hi, c[W-1:1]};
            2'b10: return {c[W-2:0], lo};
            default: return p;
        endcase
    endfunction

    // driver: apply inputs mid-cycle, confirm no change before the edge (R8), queue the expectation
    task automatic step(input logic rn, input logic [1:0] op, input logic hi, input logic lo,
                        input logic [W-1:0] p, input string tag);
        @(negedge clk);
        arst_n = rn; op_sel = op; fill_hi = hi; fill_lo = lo; par_in = p;
        #1;
        check("R8 between edges", q, cur);
        cur = model(cur, rn, op, hi, lo, p);
        exp_q.push_back(cur);
        tag_q.push_back(tag);
        @(posedge clk);
        #2;
    endtask

    // monitor: after each edge pop one expectation and compare
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), q, exp_q.pop_front());
        end
    end

    initial begin
        #1 arst_n = 1'b0;
        #5;
        check("R1 reset state", q, '0);
        step(1'b0, 2'b11, 1'b1, 1'b1, 4'b1111, "R6 edge under clear");
        step(1'b1, 2'b11, 1'b0, 1'b0, 4'b1011, "R5 load 1011");
        step(1'b1, 2'b00, 1'b1, 1'b1, 4'b0100, "R2 keep, R7 par ignored");
        step(1'b1, 2'b00, 1'b0, 1'b1, 4'b1111, "R2 keep again");
        // downward moves with fill_lo toggling (R3, R7)
        step(1'b1, 2'b01, 1'b1, 1'b0, 4'b0000, "R3 down fill 1");
        step(1'b1, 2'b01, 1'b0, 1'b1, 4'b1111, "R3 down fill 0, R7 lo ignored");
        step(1'b1, 2'b01, 1'b1, 1'b1, 4'b0101, "R3 down fill 1, R7");
        // delay line: a single one travels to bit 0 (R9)
        step(1'b1, 2'b11, 1'b0, 1'b0, 4'b0000, "R5 load 0000");
        step(1'b1, 2'b01, 1'b1, 1'b0, 4'b0000, "R9 enter top");
        step(1'b1, 2'b01, 1'b0, 1'b0, 4'b0000, "R9 move 2");
        step(1'b1, 2'b01, 1'b0, 1'b0, 4'b0000, "R9 move 3");
        step(1'b1, 2'b01, 1'b0, 1'b0, 4'b0000, "R9 reaches bit0");
        check("R9 lsb", {3'b000, q[0]}, 4'b0001);
        // upward moves with fill_hi toggling (R4, R7)
        step(1'b1, 2'b10, 1'b1, 1'b1, 4'b1010, "R4 up fill 1, R7 hi ignored");
        step(1'b1, 2'b10, 1'b0, 1'b0, 4'b1111, "R4 up fill 0");
        step(1'b1, 2'b10, 1'b1, 1'b1, 4'b0000, "R4 up fill 1");
        step(1'b1, 2'b10, 1'b1, 1'b0, 4'b0110, "R4 up fill 0, R7");
        step(1'b1, 2'b11, 1'b0, 1'b0, 4'b1111, "R5 load 1111");
        step(1'b1, 2'b11, 1'b1, 1'b1, 4'b0110, "R5 load 0110");
        step(1'b1, 2'b11, 1'b0, 1'b1, 4'b1001, "R5 load 1001");
        // clear between edges (R1), then held across a load edge (R6)
        @(negedge clk);
        #1.2 arst_n = 1'b0;
        #0.5;
        check("R1 async clear", q, '0);
        cur = '0;
        step(1'b0, 2'b11, 1'b1, 1'b1, 4'b1110, "R6 load blocked");
        step(1'b1, 2'b11, 1'b0, 1'b0, 4'b1010, "R6 first edge after release");
        step(1'b1, 2'b00, 1'b1, 1'b0, 4'b0101, "R2 keep after release");
        repeat (3) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule